// File: doc/BRIEF.md
# Fixed-Width Strobe Generator

This block turns a one-cycle trigger into a strobe that stays high for a fixed number of clock cycles and then drops by itself. The width is a parameter and defaults to one hundred cycles. A busy flag follows the strobe, so logic that waits for the window to close can use whichever output fits it.

The end of the window needs no comparator against a constant. A signed down-counter is one bit wider than the count requires. A trigger loads it with the width minus two, and it counts down once per active cycle. The window closes when the sign bit turns on. The decrementer both advances the count and signals its end.

A trigger that comes while the strobe is already high restarts the window, so the strobe then lasts a full width from the newest trigger. A trigger in the last high cycle extends the strobe without a gap.

Top module: `strobe_timer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with no trigger, strobe_o and busy_o are 0. A reset in the middle of a pulse ends that pulse at once.
- R2: When trig_i is 1 at a rising clock edge while the block is idle, strobe_o is 1 from that edge on for exactly PULSE_W clock cycles, and is 0 after the edge PULSE_W cycles later.
- R3: busy_o carries the same value as strobe_o in every cycle.
- R4: When trig_i is 1 at an edge while strobe_o is already 1, the strobe stays high for exactly PULSE_W cycles counted from that edge.
- R5: When trig_i is 1 at the edge that would otherwise end the pulse, strobe_o does not drop for any cycle and stays high for PULSE_W more cycles.
- R6: When no trigger arrives, an idle strobe stays 0, and a strobe that has ended stays 0.
- R7: The timing of R2, R4 and R5 holds for the smallest allowed width, PULSE_W = 2, and also for a width that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start or restart of the strobe, sampled on each edge |
| strobe_o | output | 1 | Fixed-width strobe |
| busy_o | output | 1 | High while the strobe is active |

## Verification
A counter that loads the wrong value, or that decrements one time too many or too few, shows at the ports as a strobe that is one or more cycles too long or too short. This appears on the falling edge of the first pulse after the trigger, at most PULSE_W cycles later. A counter that fails to park with its sign bit set while idle appears on the next trigger, as a strobe that ends early or never ends. A retrigger that does not reload shows as a fall that comes too early, measured from the second trigger. The bench therefore compares every cycle against a reference with three widths, including the minimum width, so that errors of one cycle at either end are visible.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;

  // Bits needed to hold PULSE_W-2 down to -1 as a signed value.
  function automatic int cnt_width(int pulse_w);
    return $clog2(pulse_w) + 1;
  endfunction

endpackage

// File: rtl/strobe_down_counter.sv
module strobe_down_counter #(
  parameter int W    = 8,
  parameter int LOAD = 98
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic done_o
);

  localparam logic signed [W-1:0] LoadVal = W'(LOAD);

  logic signed [W-1:0] cnt_q;

  // Reset parks the counter at -1: sign bit set means idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '1;
    else if (load_i)                  cnt_q <= LoadVal;
    else if (dec_i && !cnt_q[W-1])    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = cnt_q[W-1];

endmodule

// File: rtl/strobe_flag.sv
module strobe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~done_i);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int PULSE_W = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic strobe_o,
  output logic busy_o
);

  localparam int CntW = strobe_timer_pkg::cnt_width(PULSE_W);
  localparam int Load = PULSE_W - 2;

  if (PULSE_W < 2) begin : g_bad_width
    $error("strobe_timer: PULSE_W must be at least 2");
  end

  logic cnt_done;
  logic strobe_q;

  strobe_down_counter #(
    .W    (CntW),
    .LOAD (Load)
  ) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (trig_i),
    .dec_i  (strobe_q),
    .done_o (cnt_done)
  );

  strobe_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trig_i),
    .done_i (cnt_done),
    .flag_o (strobe_q)
  );

  assign strobe_o = strobe_q;
  assign busy_o   = strobe_q;

endmodule

// File: rtl/strobe_timer_chk.sv
module strobe_timer_chk #(
  parameter int PULSE_W = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_i,
  input logic strobe_o,
  input logic busy_o,
  input logic cnt_done_i
);

  // Independent window tracker: cycles left after the current one.
  int   left_q;
  logic exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= 0;
      exp_q  <= 1'b0;
    end else begin
      exp_q  <= trig_i || (left_q != 0);
      left_q <= trig_i ? PULSE_W - 1 : (left_q != 0 ? left_q - 1 : 0);
    end
  end

  // R2
  trig_sets_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> strobe_o);

  // R6
  idle_stays_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_o && !trig_i) |=> !strobe_o);

  // R4 R5
  window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o == exp_q);

  // R1
  idle_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> cnt_done_i);

  // R3
  busy_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> busy_o);

endmodule

bind strobe_timer strobe_timer_chk #(.PULSE_W(PULSE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig_i),
  .strobe_o   (strobe_o),
  .busy_o     (busy_o),
  .cnt_done_i (cnt_done)
);

// File: tb/test_strobe_timer.sv
module test_strobe_timer;

  localparam int NW = 3;
  localparam int W0 = 100;
  localparam int W1 = 2;
  localparam int W2 = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic [NW-1:0] stb, bsy;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";
  int widths [NW] = '{W0, W1, W2};
  int rem [NW];

  always #10 clk = ~clk; // 50 MHz

  strobe_timer #(.PULSE_W(W0)) i_strobe_timer (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .strobe_o(stb[0]), .busy_o(bsy[0]));
  strobe_timer #(.PULSE_W(W1)) i_strobe_timer_w2 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .strobe_o(stb[1]), .busy_o(bsy[1]));
  strobe_timer #(.PULSE_W(W2)) i_strobe_timer_w5 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .strobe_o(stb[2]), .busy_o(bsy[2]));

  // Reference: a trigger opens a window of widths[i] cycles from that edge.
  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < NW; i++) begin
      if (!rst_n)      rem[i] = 0;
      else if (trig)   rem[i] = widths[i];
      else if (rem[i] > 0) rem[i] = rem[i] - 1;
    end
  end

  task automatic check(string req, int idx, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s w=%0d %s t=%0t actual=%b expected=%b",
               req, widths[idx], what, $time, act, exp);
    end
  endtask

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int i = 0; i < NW; i++) begin
        check(tag, i, stb[i], rem[i] > 0, "strobe");
        check("R3", i, bsy[i], stb[i], "busy");
      end
    end
  end

  task automatic pulse();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
    finish_run();
  end

  initial begin
    // R1: outputs low in reset
    idle(3);
    for (int i = 0; i < NW; i++) begin
      check("R1", i, stb[i], 1'b0, "strobe in reset");
      check("R1", i, bsy[i], 1'b0, "busy in reset");
    end
    rst_n = 1'b1;
    tag = "R1";
    idle(2);
    tag = "R6";
    idle(10);

    tag = "R2";
    pulse();
    idle(W0 + 10);

    tag = "R4";
    pulse();
    idle(40);
    pulse();
    idle(W0 + 10);
    // retrigger for small widths
    tag = "R7";
    pulse();
    idle(2);
    pulse();
    idle(8);
    trig = 1'b1;
    idle(6);
    trig = 1'b0;
    idle(W0 + 5);

    // R5: trigger on the edge that would end the pulse
    tag = "R5";
    pulse();
    idle(W0 - 1);
    pulse();
    idle(W0 + 5);
    tag = "R7";
    pulse();
    idle(W1 - 1);
    pulse();
    idle(W2 - 1);
    pulse();
    idle(W0 + 5);

    tag = "R6";
    idle(20);

    // R1: reset in mid-pulse ends it
    tag = "R1";
    pulse();
    idle(3);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NW; i++)
      check("R1", i, stb[i], 1'b0, "strobe after mid-pulse reset");
    idle(2);
    rst_n = 1'b1;
    idle(5);
    finish_run();
  end

endmodule